// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns a predicate description into two per-element enable masks, one for the source side and one for the destination side of a vector instruction. A start strobe captures the predicate mode, the predicate type, the two selector codes, the vector length and the base condition field. The block then walks the elements one per clock cycle and fills in one bit of each mask per step. A one-cycle done strobe marks the end of the walk. The masks hold their values until the next start.

The block has two modes. In condition mode, each element reads its own 4-bit condition field, numbered base plus element index. The selector picks one bit of that field and the value the bit must have. In integer mode, the selector picks one of the supplied integer register values, with an optional complement, or it picks an all-ones mask. With the single predicate type, both masks come from the destination selector. With the twin type, the source mask is derived from its own selector.

Top module: `pmask_gen`

## Requirements
- R1: After synchronous reset, `src_mask` and `dst_mask` are zero and `done` is low.
- R2: In condition mode (`pred_mode`=1), the selector codes 0..7 map to (bit index, expected value) as follows: 0=(0,1), 1=(0,0), 2=(1,1), 3=(1,0), 4=(2,1), 5=(2,0), 6=(3,1), 7=(3,0). Within a 4-bit field, bit index 0 is the field's most significant bit. Mask bit i is 1 exactly when the selected bit equals the expected value.
- R3: Element i reads condition field (cr_base + i) modulo 128. Field f occupies `cr_file[4f+3:4f]`.
- R4: Mask bits at positions at or above the vector length are 0. A `vec_len` above 64 is treated as 64.
- R5: With `twin_pred`=0, `src_mask` equals `dst_mask`, and both are derived from `dst_sel`.
- R6: With `twin_pred`=1, `src_mask` is derived from `src_sel` in the same mode, independently of `dst_mask`.
- R7: In integer mode (`pred_mode`=0), selector bits [2:1] choose register k = `int_regs[64k+63:64k]` for k<3, and bit 0 set complements that value. Codes 6 and 7 give all ones. Bit i of the mask is bit i of the result.
- R8: If start is sampled at edge E and the effective length is n, `done` is high for exactly one cycle, following edge E+n. With n=0 this is the cycle right after E. The timing is the same in both modes.
- R9: A start sampled while a walk is in progress abandons that walk. The masks restart from zero, and timing follows R8 from the new start.
- R10: After `done`, both masks hold their values and `done` stays low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture configuration and begin a mask walk |
| pred_mode | input | 1 | 1 = condition-field mode, 0 = integer-register mode |
| twin_pred | input | 1 | 1 = separate source selector, 0 = source follows destination |
| src_sel | input | 3 | Source selector code |
| dst_sel | input | 3 | Destination selector code |
| vec_len | input | 7 | Vector length, 0..64 (larger values clamp to 64) |
| cr_base | input | 7 | First condition field used by element 0 |
| cr_file | input | 512 | 128 condition fields of 4 bits each |
| int_regs | input | 192 | Three 64-bit integer predicate values |
| src_mask | output | 64 | Source element enable mask |
| dst_mask | output | 64 | Destination element enable mask |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench sweeps all eight condition selectors and all eight integer selectors over lengths 0, 1, 2, 5, 63, 64 and an over-range value. It uses base fields near the top of the field file so that the index wraps. A swapped bit index or polarity shows up as a mask that is inverted or shifted against the bench's own bit extraction. A missing wrap reads the wrong fields. Stray high bits betray a length bound that is not enforced. The bench measures the latency of every walk, including zero length, and catches an off-by-one done. It restarts a walk halfway to expose partial masks that were not cleared. It checks single against twin operation, including the case where only the source selector differs, and watches the masks stay frozen after completion.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
  localparam int XLEN       = 64;
  localparam int NUM_INT    = 3;
  localparam int CR_FIELDS  = 128;
  localparam int SEL_W      = 3;

  typedef struct packed {
    logic [1:0] bit_idx;
    logic       expect_val;
  } cr_test_t;
endpackage

// File: rtl/pmask_cr_decode.sv
module pmask_cr_decode
  import pmask_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output cr_test_t         test
);
  always_comb begin
    unique case (sel)
      3'd0: test = '{bit_idx: 2'd0, expect_val: 1'b1};
      3'd1: test = '{bit_idx: 2'd0, expect_val: 1'b0};
      3'd2: test = '{bit_idx: 2'd1, expect_val: 1'b1};
      3'd3: test = '{bit_idx: 2'd1, expect_val: 1'b0};
      3'd4: test = '{bit_idx: 2'd2, expect_val: 1'b1};
      3'd5: test = '{bit_idx: 2'd2, expect_val: 1'b0};
      3'd6: test = '{bit_idx: 2'd3, expect_val: 1'b1};
      default: test = '{bit_idx: 2'd3, expect_val: 1'b0};
    endcase
  end
endmodule

// File: rtl/pmask_int_pick.sv
module pmask_int_pick
  import pmask_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int NREGS  = NUM_INT,
  parameter int ELEM_W = $clog2(W)
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ELEM_W-1:0] elem,
  input  logic [NREGS*W-1:0] regs,
  output logic              bit_out
);
  logic [1:0]   reg_no;
  logic         hit_reg;
  logic [W-1:0] value;

  assign reg_no = sel[2:1];

  always_comb begin
    value   = '0;
    hit_reg = 1'b0;
    for (int k = 0; k < NREGS; k++) begin
      if (reg_no == 2'(k)) begin
        value   = regs[k*W +: W];
        hit_reg = 1'b1;
      end
    end
    bit_out = hit_reg ? (value[elem] ^ sel[0]) : 1'b1;
  end
endmodule

// File: rtl/pmask_lane.sv
module pmask_lane
  import pmask_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int NREGS   = NUM_INT,
  parameter int NFIELDS = CR_FIELDS,
  parameter int ELEM_W  = $clog2(W),
  parameter int FLD_W   = $clog2(NFIELDS)
) (
  input  logic               cr_mode,
  input  logic [SEL_W-1:0]   sel,
  input  logic [FLD_W-1:0]   base,
  input  logic [ELEM_W-1:0]  elem,
  input  logic [NFIELDS*4-1:0] cr_file,
  input  logic [NREGS*W-1:0] int_regs,
  output logic               bit_out
);
  cr_test_t           test;
  logic [FLD_W-1:0]   fld;
  logic [FLD_W+1:0]   pos;
  logic               cr_bit;
  logic               int_bit;

  pmask_cr_decode u_dec (.sel(sel), .test(test));

  pmask_int_pick #(.W(W), .NREGS(NREGS), .ELEM_W(ELEM_W)) u_int (
    .sel(sel), .elem(elem), .regs(int_regs), .bit_out(int_bit)
  );

  assign fld     = base + FLD_W'(elem);
  assign pos     = {fld, ~test.bit_idx};
  assign cr_bit  = cr_file[pos];
  assign bit_out = cr_mode ? (cr_bit == test.expect_val) : int_bit;
endmodule

// File: rtl/pmask_gen.sv
module pmask_gen
  import pmask_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int NREGS   = NUM_INT,
  parameter int NFIELDS = CR_FIELDS,
  parameter int VL_W    = $clog2(W + 1),
  parameter int FLD_W   = $clog2(NFIELDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 pred_mode,
  input  logic                 twin_pred,
  input  logic [SEL_W-1:0]     src_sel,
  input  logic [SEL_W-1:0]     dst_sel,
  input  logic [VL_W-1:0]      vec_len,
  input  logic [FLD_W-1:0]     cr_base,
  input  logic [NFIELDS*4-1:0] cr_file,
  input  logic [NREGS*W-1:0]   int_regs,
  output logic [W-1:0]         src_mask,
  output logic [W-1:0]         dst_mask,
  output logic                 done
);
  localparam int ELEM_W = $clog2(W);
  localparam int NLANE  = 2;

  logic               mode_q;
  logic               twin_q;
  logic [SEL_W-1:0]   sel_q [NLANE];
  logic [VL_W-1:0]    vl_q;
  logic [FLD_W-1:0]   base_q;
  logic [VL_W-1:0]    elem_q;
  logic               busy;
  logic [VL_W-1:0]    vl_eff;
  logic [NLANE-1:0]   lane_bit;

  assign vl_eff = (vec_len > VL_W'(W)) ? VL_W'(W) : vec_len;

  // lane 0 = destination, lane 1 = source
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    pmask_lane #(.W(W), .NREGS(NREGS), .NFIELDS(NFIELDS)) u_lane (
      .cr_mode (mode_q),
      .sel     (sel_q[g]),
      .base    (base_q),
      .elem    (elem_q[ELEM_W-1:0]),
      .cr_file (cr_file),
      .int_regs(int_regs),
      .bit_out (lane_bit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      twin_q   <= 1'b0;
      sel_q[0] <= '0;
      sel_q[1] <= '0;
      vl_q     <= '0;
      base_q   <= '0;
      elem_q   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      src_mask <= '0;
      dst_mask <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        mode_q   <= pred_mode;
        twin_q   <= twin_pred;
        sel_q[0] <= dst_sel;
        sel_q[1] <= twin_pred ? src_sel : dst_sel;
        vl_q     <= vl_eff;
        base_q   <= cr_base;
        elem_q   <= '0;
        src_mask <= '0;
        dst_mask <= '0;
        busy     <= (vl_eff != '0);
        done     <= (vl_eff == '0);
      end else if (busy) begin
        dst_mask[elem_q[ELEM_W-1:0]] <= lane_bit[0];
        src_mask[elem_q[ELEM_W-1:0]] <= lane_bit[1];
        elem_q <= elem_q + 1'b1;
        if (elem_q == vl_q - 1'b1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pmask_gen_chk.sv
module pmask_gen_chk #(
  parameter int W    = 64,
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            done,
  input logic            busy,
  input logic            twin_q,
  input logic [VL_W-1:0] vl_q,
  input logic [W-1:0]    src_mask,
  input logic [W-1:0]    dst_mask
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done);

  p_no_done_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  p_bound_vl_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> ((dst_mask >> vl_q) == '0) && ((src_mask >> vl_q) == '0));

  p_single_same_r5: assert property (@(posedge clk) disable iff (rst)
    done && !twin_q |-> src_mask == dst_mask);

  p_start_clear_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> (src_mask == '0) && (dst_mask == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(src_mask) && $stable(dst_mask));
endmodule

bind pmask_gen pmask_gen_chk #(.W(W), .VL_W(VL_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .done(done), .busy(busy),
  .twin_q(twin_q), .vl_q(vl_q), .src_mask(src_mask), .dst_mask(dst_mask)
);

// File: tb/pmask_gen_tb.sv
module pmask_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 64;
  localparam int NF = 128;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic         pred_mode;
  logic         twin_pred;
  logic [2:0]   src_sel;
  logic [2:0]   dst_sel;
  logic [6:0]   vec_len;
  logic [6:0]   cr_base;
  logic [NF*4-1:0] cr_file;
  logic [3*W-1:0]  int_regs;
  logic [W-1:0] src_mask;
  logic [W-1:0] dst_mask;
  logic         done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmask_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .pred_mode(pred_mode),
    .twin_pred(twin_pred), .src_sel(src_sel), .dst_sel(dst_sel),
    .vec_len(vec_len), .cr_base(cr_base), .cr_file(cr_file),
    .int_regs(int_regs), .src_mask(src_mask), .dst_mask(dst_mask),
    .done(done)
  );

  function automatic logic [W-1:0] ref_mask(input logic md, input logic [2:0] sel,
                                            input int vl, input int base);
    logic [W-1:0] m = '0;
    int n = (vl > W) ? W : vl;
    for (int i = 0; i < n; i++) begin
      if (md) begin
        int f   = (base + i) % NF;
        int idx = sel / 2;
        logic ev = (sel % 2 == 0);
        m[i] = (cr_file[4*f + 3 - idx] == ev);
      end else begin
        int r = sel / 2;
        if (r >= 3) m[i] = 1'b1;
        else m[i] = int_regs[r*W + i] ^ sel[0];
      end
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic randomize_state();
    for (int k = 0; k < NF*4/32; k++) cr_file[k*32 +: 32] = $urandom;
    for (int k = 0; k < 3*W/32; k++) int_regs[k*32 +: 32] = $urandom;
  endtask

  // drive a walk and return the number of edges after the start edge until done
  task automatic run(input logic md, input logic tw, input logic [2:0] ss,
                     input logic [2:0] ds, input int vl, input int base,
                     output int lat);
    @(negedge clk);
    pred_mode = md; twin_pred = tw; src_sel = ss; dst_sel = ds;
    vec_len = 7'(vl); cr_base = 7'(base); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_check(input string req, input logic md, input logic tw,
                           input logic [2:0] ss, input logic [2:0] ds,
                           input int vl, input int base);
    int lat;
    logic [W-1:0] ed, es;
    int n = (vl > W) ? W : vl;
    run(md, tw, ss, ds, vl, base, lat);
    ed = ref_mask(md, ds, vl, base);
    es = tw ? ref_mask(md, ss, vl, base) : ed;
    chk({req, " dst"}, dst_mask, ed);
    chk({req, " src"}, src_mask, es);
    chk("R8 latency", W'(lat), W'(n));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int vls[7] = '{0, 1, 2, 5, 63, 64, 100};
    int lat;
    logic [W-1:0] hold_s, hold_d;
    rst = 1'b1; start = 1'b0; pred_mode = 1'b0; twin_pred = 1'b0;
    src_sel = '0; dst_sel = '0; vec_len = '0; cr_base = '0;
    cr_file = '0; int_regs = '0;
    repeat (3) @(negedge clk);
    chk("R1 dst reset", dst_mask, '0);
    chk("R1 src reset", src_mask, '0);
    chk("R1 done reset", W'(done), '0);
    rst = 1'b0;

    // two-element example: field 4 EQ=1, field 5 EQ=0, select NE (5)
    cr_file = '0;
    cr_file[4*4 + 1] = 1'b1;
    run(1'b1, 1'b0, 3'd0, 3'd5, 2, 4, lat);
    chk("R2 ne example", dst_mask, 64'b10);

    // condition-mode sweep (R2, R3, R4, R5)
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 7; v++) begin
        randomize_state();
        run_check("R2 R3 R4 R5 cr single", 1'b1, 1'b0, 3'(7 - s), 3'(s), vls[v], 90 + 5*v);
      end
    end

    // integer-mode sweep (R7, R4)
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 7; v++) begin
        randomize_state();
        run_check("R7 R4 int single", 1'b0, 1'b0, 3'(s ^ 1), 3'(s), vls[v], 0);
      end
    end

    // twin predicate in both modes (R6)
    for (int s = 0; s < 8; s++) begin
      randomize_state();
      run_check("R6 cr twin", 1'b1, 1'b1, 3'(s), 3'((s + 3) % 8), 64, 120);
      run_check("R6 int twin", 1'b0, 1'b1, 3'(s), 3'((s + 5) % 8), 37, 0);
    end

    // restart in the middle of a walk (R9)
    randomize_state();
    @(negedge clk);
    pred_mode = 1'b1; twin_pred = 1'b1; src_sel = 3'd0; dst_sel = 3'd1;
    vec_len = 7'd40; cr_base = 7'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    run_check("R9 restart", 1'b1, 1'b0, 3'd2, 3'd4, 12, 17);

    // hold after done (R10)
    hold_s = src_mask; hold_d = dst_mask;
    cr_file = ~cr_file;
    repeat (6) begin
      @(negedge clk);
      chk("R10 hold dst", dst_mask, hold_d);
      chk("R10 hold src", src_mask, hold_s);
      chk("R10 done low", W'(done), '0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule